// File: doc/BRIEF.md
# Indexed Register Stream Loader

This block turns a stream of 32-bit words arriving on one data port into writes to a small set of command-queue configuration registers. Each word names its target through an index in its upper bits and carries a 24-bit payload in its lower bits. A separate select register picks which register space the following words are decoded in. One space uses the top byte directly as the index. The other space requires a qualifier bit in every word.

The full 32-bit queue start and end addresses are built from pieces. One word carries the low 24 bits of the start address and another carries the low 24 bits of the end address. A third word carries the high byte of both. A fourth word carries the queue length, counted in 8-byte units. The end address is inclusive, so it equals the start address plus the queue size minus one. Once all four words have arrived since the last select write, and the end address is not below the start address, the block raises its queue-enable output.

Words arrive on a valid/ready port. A word is taken on any clock edge where both `word_valid` and `word_ready` are high. The block holds `word_ready` low only during a cycle in which the select register is being written; there it applies the select and leaves the word pending. A sender that keeps `word_valid` high with the same data simply has the word taken on the next cycle. Indices the block does not know are dropped and flagged in a sticky status bit.

Top module: `irsl_top`

## Requirements
- R1: In the plain space, word bits [31:24] are the index and bits [23:0] the payload. Index 0x50 loads `q_start[23:0]` and index 0x51 loads `q_end[23:0]`.
- R2: Index 0x52 loads `q_start[31:24]` from payload bits [7:0] and `q_end[31:24]` from payload bits [15:8] in one word.
- R3: Index 0x53 loads `q_len` with the 24-bit payload unchanged; the unit is 8 bytes.
- R4: A select write updates `cur_space`. Data 0x00FE0000 gives 1 (plain space), data 0x00100000 gives 2 (qualified space) and any other value gives 0 (no space, where every word is unknown). Reset gives 0.
- R5: In the qualified space a word must have bit 29 set. Its index is {bits[31:30], 0, bits[28:24]}, so top bytes 0x70..0x73 load the same registers as 0x50..0x53 do in the plain space. A word with bit 29 clear is unknown.
- R6: An unknown word changes no queue register and sets `err_sticky`. `err_sticky` stays set until reset.
- R7: `q_en` is high exactly when all four queue words have been taken since the last select write and `q_end >= q_start` (unsigned). A select write clears the received set and keeps the register values.
- R8: `word_ready` is the inverse of `sel_wr`. A word taken at a clock edge is visible on the outputs right after that edge. Without a taken word or a select write, no output changes.
- R9: After reset, `q_start`, `q_end`, `q_len`, `q_en`, `err_sticky` and `cur_space` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Write strobe for the space select register |
| sel_data | input | 32 | Value written to the select register |
| word_valid | input | 1 | A stream word is offered |
| word_ready | output | 1 | The block can take a word this cycle |
| word_data | input | 32 | Stream word: index field above, payload below |
| cur_space | output | 2 | Selected space: 0 none, 1 plain, 2 qualified |
| q_start | output | 32 | Queue start address |
| q_end | output | 32 | Queue end address, inclusive |
| q_len | output | 24 | Queue length in 8-byte units |
| q_en | output | 1 | Queue enable |
| err_sticky | output | 1 | An unknown word has been dropped since reset |

## Verification
Several properties are checked on every cycle. `q_en` never shows an end address below the start address. A select write drops the enable and leaves the queue registers untouched. The error flag never falls. Without a taken word the registers hold, and a plain-space word outside 0x50..0x53 changes nothing and raises the flag. The bench scenarios show the rest: the correct field-to-register placement, the split of the high-byte word, the qualifier-bit decode in the second space, and the requirement that all four words arrive after the most recent select write. A reference model in the bench tracks these over long random mixes of select writes, known words, unknown words and clashes between a select write and an offered word.

// File: rtl/irsl_pkg.sv
package irsl_pkg;
  localparam int WORD_W  = 32;
  localparam int IDX_W   = 8;
  localparam int PAY_W   = WORD_W - IDX_W;
  localparam int HI_W    = WORD_W - PAY_W;
  localparam int NUM_Q   = 4;
  localparam logic [IDX_W-1:0] Q_BASE = 8'h50;

  localparam int SLOT_START = 0;
  localparam int SLOT_END   = 1;
  localparam int SLOT_HIGH  = 2;
  localparam int SLOT_LEN   = 3;

  typedef enum logic [1:0] {
    SP_NONE  = 2'd0,
    SP_PLAIN = 2'd1,
    SP_QUAL  = 2'd2
  } space_e;
endpackage

// File: rtl/irsl_decode.sv
module irsl_decode
  import irsl_pkg::*;
#(
  parameter int QUAL_BIT = 29
) (
  input  space_e             space,
  input  logic [IDX_W-1:0]   top,
  output logic [NUM_Q-1:0]   hit,
  output logic               unknown
);
  localparam int QPOS = QUAL_BIT - PAY_W;

  logic             idx_ok;
  logic [IDX_W-1:0] eff_idx;

  always_comb begin
    idx_ok  = 1'b0;
    eff_idx = top;
    unique case (space)
      SP_PLAIN: begin
        idx_ok  = 1'b1;
        eff_idx = top;
      end
      SP_QUAL: begin
        idx_ok  = top[QPOS];
        eff_idx = top;
        eff_idx[QPOS] = 1'b0;
      end
      default: begin
        idx_ok  = 1'b0;
        eff_idx = top;
      end
    endcase
  end

  for (genvar k = 0; k < NUM_Q; k++) begin : g_hit
    assign hit[k] = idx_ok && (eff_idx == (Q_BASE + IDX_W'(k)));
  end

  assign unknown = ~|hit;
endmodule

// File: rtl/irsl_regs.sv
module irsl_regs
  import irsl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [NUM_Q-1:0]    hit,
  input  logic [PAY_W-1:0]    payload,
  output logic [WORD_W-1:0]   q_start,
  output logic [WORD_W-1:0]   q_end,
  output logic [PAY_W-1:0]    q_len
);
  logic [PAY_W-1:0] start_lo, end_lo;
  logic [HI_W-1:0]  start_hi, end_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_lo <= '0;
      end_lo   <= '0;
      start_hi <= '0;
      end_hi   <= '0;
      q_len    <= '0;
    end else if (take) begin
      if (hit[SLOT_START]) start_lo <= payload;
      if (hit[SLOT_END])   end_lo   <= payload;
      if (hit[SLOT_HIGH]) begin
        start_hi <= payload[HI_W-1:0];
        end_hi   <= payload[2*HI_W-1:HI_W];
      end
      if (hit[SLOT_LEN])   q_len    <= payload;
    end
  end

  assign q_start = {start_hi, start_lo};
  assign q_end   = {end_hi, end_lo};
endmodule

// File: rtl/irsl_track.sv
module irsl_track
  import irsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [NUM_Q-1:0]  hit,
  input  logic [WORD_W-1:0] q_start,
  input  logic [WORD_W-1:0] q_end,
  output logic              q_en
);
  logic [NUM_Q-1:0] seen;

  for (genvar k = 0; k < NUM_Q; k++) begin : g_seen
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                seen[k] <= 1'b0;
      else if (clear)            seen[k] <= 1'b0;
      else if (take && hit[k])   seen[k] <= 1'b1;
    end
  end

  assign q_en = (&seen) && (q_end >= q_start);
endmodule

// File: rtl/irsl_top.sv
module irsl_top
  import irsl_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEL_PLAIN = 32'h00FE_0000,
  parameter logic [WORD_W-1:0] SEL_QUAL  = 32'h0010_0000,
  parameter int                QUAL_BIT  = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [WORD_W-1:0] sel_data,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic [1:0]        cur_space,
  output logic [WORD_W-1:0] q_start,
  output logic [WORD_W-1:0] q_end,
  output logic [PAY_W-1:0]  q_len,
  output logic              q_en,
  output logic              err_sticky
);
  space_e           space_q;
  logic [NUM_Q-1:0] hit;
  logic             unknown;
  logic             take;

  assign word_ready = !sel_wr;
  assign take       = word_valid && word_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) space_q <= SP_NONE;
    else if (sel_wr) begin
      if (sel_data == SEL_PLAIN)     space_q <= SP_PLAIN;
      else if (sel_data == SEL_QUAL) space_q <= SP_QUAL;
      else                           space_q <= SP_NONE;
    end
  end
  assign cur_space = space_q;

  irsl_decode #(.QUAL_BIT(QUAL_BIT)) u_decode (
    .space   (space_q),
    .top     (word_data[WORD_W-1:PAY_W]),
    .hit     (hit),
    .unknown (unknown)
  );

  irsl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .hit     (hit),
    .payload (word_data[PAY_W-1:0]),
    .q_start (q_start),
    .q_end   (q_end),
    .q_len   (q_len)
  );

  irsl_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (sel_wr),
    .take    (take),
    .hit     (hit),
    .q_start (q_start),
    .q_end   (q_end),
    .q_en    (q_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               err_sticky <= 1'b0;
    else if (take && unknown) err_sticky <= 1'b1;
  end
endmodule

// File: rtl/irsl_checker.sv
module irsl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sel_wr,
  input logic        word_valid,
  input logic        word_ready,
  input logic [31:0] word_data,
  input logic [1:0]  cur_space,
  input logic [31:0] q_start,
  input logic [31:0] q_end,
  input logic [23:0] q_len,
  input logic        q_en,
  input logic        err_sticky
);
  p_en_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_en |-> (q_end >= q_start));

  p_sel_drops_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> !q_en);

  p_sel_keeps_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> ($stable(q_start) && $stable(q_end) && $stable(q_len)));

  p_err_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && word_ready) |=>
      ($stable(q_start) && $stable(q_end) && $stable(q_len) && $stable(err_sticky)));

  p_unknown_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready && cur_space == 2'd1 &&
     (word_data[31:24] < 8'h50 || word_data[31:24] > 8'h53)) |=>
      ($stable(q_start) && $stable(q_end) && $stable(q_len) && err_sticky));
endmodule

bind irsl_top irsl_checker u_irsl_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_wr     (sel_wr),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .word_data  (word_data),
  .cur_space  (cur_space),
  .q_start    (q_start),
  .q_end      (q_end),
  .q_len      (q_len),
  .q_en       (q_en),
  .err_sticky (err_sticky)
);

// File: tb/irsl_top_bench.sv
module irsl_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr = 1'b0;
  logic [31:0] sel_data = '0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic [1:0]  cur_space;
  logic [31:0] q_start, q_end;
  logic [23:0] q_len;
  logic        q_en, err_sticky;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int          m_space;
  logic [31:0] m_start, m_end;
  logic [23:0] m_len;
  logic [3:0]  m_seen;
  logic        m_err;

  always #10 clk = ~clk;

  irsl_top u_irsl_top (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_data(sel_data),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .cur_space(cur_space), .q_start(q_start), .q_end(q_end), .q_len(q_len),
    .q_en(q_en), .err_sticky(err_sticky)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_slot(input int sp, input logic [7:0] t);
    logic [7:0] e;
    if (sp == 1) begin
      if (t >= 8'h50 && t <= 8'h53) return int'(t - 8'h50);
      return -1;
    end
    if (sp == 2) begin
      if (!t[5]) return -1;
      e = t & 8'hDF;
      if (e >= 8'h50 && e <= 8'h53) return int'(e - 8'h50);
      return -1;
    end
    return -1;
  endfunction

  function automatic logic exp_en();
    return (m_seen == 4'hF) && (m_end >= m_start);
  endfunction

  task automatic model_reset();
    m_space = 0; m_start = '0; m_end = '0; m_len = '0; m_seen = '0; m_err = 1'b0;
  endtask

  task automatic model_step(input logic sw, input logic [31:0] sd,
                            input logic wv, input logic [31:0] wd);
    int k;
    if (sw) begin
      m_space = (sd == 32'h00FE0000) ? 1 : (sd == 32'h00100000) ? 2 : 0;
      m_seen = '0;
    end else if (wv) begin
      k = exp_slot(m_space, wd[31:24]);
      if (k < 0) m_err = 1'b1;
      else begin
        m_seen[k] = 1'b1;
        case (k)
          0: m_start[23:0] = wd[23:0];
          1: m_end[23:0]   = wd[23:0];
          2: begin m_start[31:24] = wd[7:0]; m_end[31:24] = wd[15:8]; end
          default: m_len = wd[23:0];
        endcase
      end
    end
  endtask

  task automatic compare_all(input string ctx);
    check("R4", {ctx, " space"}, 32'(cur_space), 32'(m_space));
    check("R1", {ctx, " start"}, q_start, m_start);
    check("R1", {ctx, " end"},   q_end, m_end);
    check("R3", {ctx, " len"},   32'(q_len), 32'(m_len));
    check("R7", {ctx, " en"},    32'(q_en), 32'(exp_en()));
    check("R6", {ctx, " err"},   32'(err_sticky), 32'(m_err));
  endtask

  // called at a negedge; returns at the following negedge with inputs idle
  task automatic step(input string ctx, input logic sw, input logic [31:0] sd,
                      input logic wv, input logic [31:0] wd);
    sel_wr = sw; sel_data = sd; word_valid = wv; word_data = wd;
    #1;
    check("R8", {ctx, " ready"}, 32'(word_ready), 32'(!sw));
    model_step(sw, sd, wv, wd);
    @(negedge clk);
    sel_wr = 1'b0; word_valid = 1'b0;
    compare_all(ctx);
  endtask

  task automatic sel(input string ctx, input logic [31:0] v);
    step(ctx, 1'b1, v, 1'b0, '0);
  endtask

  task automatic wr(input string ctx, input logic [31:0] w);
    step(ctx, 1'b0, '0, 1'b1, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R9: reset state
    compare_all("R9 reset");
    check("R9", "ready at reset", 32'(word_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // words before any select are unknown (R4 none space)
    wr("R4 no space", 32'h5012_3456);

    // R1/R2/R3 plain load, enable when complete
    sel("R4 plain", 32'h00FE0000);
    wr("R1 start lo", 32'h5000_1000);
    wr("R1 end lo",   32'h5100_2FFF);
    wr("R2 high",     32'h5200_1211);
    check("R7", "en before len", 32'(q_en), 32'd0);
    wr("R3 len",      32'h5300_0400);
    check("R2", "start full", q_start, 32'h1100_1000);
    check("R2", "end full",   q_end,   32'h1200_2FFF);
    check("R7", "en complete", 32'(q_en), 32'd1);

    // end below start drops enable
    wr("R7 end low", 32'h5100_0001);
    wr("R2 hi equal", 32'h5200_1111);
    check("R7", "end below start", 32'(q_en), 32'd0);
    wr("R7 end equal", 32'h5100_1000);
    check("R7", "end equals start", 32'(q_en), 32'd1);

    // select clears enable, keeps registers
    sel("R7 reselect", 32'h00FE0000);
    check("R7", "en after select", 32'(q_en), 32'd0);
    check("R7", "start kept", q_start, 32'h1100_1000);

    // R6 unknown in plain space
    wr("R6 unknown", 32'h4400_0000);
    check("R6", "err set", 32'(err_sticky), 32'd1);

    // R8 select and word together: word not taken
    step("R8 clash", 1'b1, 32'h00100000, 1'b1, 32'h7000_ABCD);

    // R5 qualified space
    wr("R5 start", 32'h7000_0100);
    wr("R5 end",   32'h7100_01FF);
    wr("R5 plainidx", 32'h5200_0000);
    wr("R5 high",  32'h7200_0303);
    wr("R5 len",   32'h7300_0020);
    check("R5", "q start", q_start, 32'h0300_0100);
    check("R5", "q en", 32'(q_en), 32'd1);

    sel("R4 other", 32'h00FE0001);
    wr("R4 other word", 32'h5000_7777);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [7:0] t;
      logic [31:0] w;
      r = int'($urandom % 20);
      if (r == 0) begin
        case ($urandom % 3)
          0: sel("rand sel", 32'h00FE0000);
          1: sel("rand sel", 32'h00100000);
          default: sel("rand sel", $urandom);
        endcase
      end else if (r == 1) begin
        step("R8 rand clash", 1'b1, 32'h00FE0000, 1'b1, $urandom);
      end else begin
        case ($urandom % 5)
          0, 1: t = 8'h50 + 8'($urandom % 4);
          2, 3: t = 8'h70 + 8'($urandom % 4);
          default: t = 8'($urandom);
        endcase
        w = {t, 24'($urandom)};
        wr("rand word", w);
      end
    end

    // R9 reset again mid-run
    rst_n = 1'b0;
    model_reset();
    #1;
    compare_all("R9 reassert");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule